// File: doc/BRIEF.md
# Polarity-Aware Dead-Time Gate Controller

This block turns one PWM command into the two gate enables of a single inverter phase leg. It also takes two flags that say which free-wheeling diode of the leg is conducting. From these flags it works out the direction of the load current.

When the current direction is known, the block pulses only the switch that carries the current and keeps its partner off. No blanking time is spent in that case, and the output voltage edges follow the command with one cycle of latency. When the direction is unknown, meaning both flags or neither flag is set, the block falls back to complementary switching. In that mode it inserts a programmable interval in which both gates are off.

The diode flags are asynchronous to the clock. They go through a two-flop synchronizer, and a consecutive-sample filter qualifies them before use. A new switching mode takes effect only at an edge of the PWM command.

Top module: `dtg_gate_ctrl`

## Requirements
- R1: The upper and lower gate outputs are never both high in the same clock cycle, in any mode.
- R2: A synchronous reset drives both gates low and selects the unknown-polarity mode. After reset the gates stay low until the first PWM command edge.
- R3: Polarity is decoded from the qualified flags as follows. The lower-diode flag alone means positive current, flowing out of the leg. The upper-diode flag alone means negative current. Both flags or neither flag means unknown, which selects complementary switching.
- R4: Each diode flag passes through two synchronizer flops. A new polarity value is accepted only after it has been present for FILT_LEN consecutive samples, so shorter pulses are ignored.
- R5: In complementary mode, at each command edge (seen at clock E), the gate that was on is low from E+1. The other gate goes high at E+D+1, where D is the dead-time count; a count of 0 is treated as 1. A high command drives the upper gate and a low command drives the lower gate.
- R6: In positive mode, the upper gate follows the command, changing one cycle after each command edge. The lower gate stays low and no blanking is added.
- R7: In negative mode, the lower gate follows the inverted command, changing one cycle after each command edge. The upper gate stays low.
- R8: The mode is latched only at a command edge. A polarity change between edges leaves both gates unchanged.
- R9: Entering complementary mode from either single-switch mode always begins with a full dead interval with both gates low, even if both gates were already low.
- R10: If an edge would turn a gate on while the other gate is still on, a full dead interval is inserted first. This also applies to a direct change between the positive and negative modes.
- R11: A command edge that arrives during a dead interval restarts the full interval, measured from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_cmd | input | 1 | PWM command; high requests the leg output at the positive rail |
| dio_lo_cond | input | 1 | Lower free-wheeling diode conducting (asynchronous) |
| dio_hi_cond | input | 1 | Upper free-wheeling diode conducting (asynchronous) |
| dead_cnt | input | DT_W | Dead-time length in clock cycles (0 acts as 1) |
| gate_hi | output | 1 | Upper switch gate enable |
| gate_lo | output | 1 | Lower switch gate enable |

## Verification
The bench builds the block with DT_W = 5 and FILT_LEN = 3. The 5-bit width keeps the all-ones count of 31 within reach, so the longest dead interval is checked cycle by cycle next to the zero count that is promoted to one cycle. A filter length of 3 allows a two-cycle flag pulse that must be rejected, while a settled polarity is still accepted within a few cycles. This makes mode changes between the positive, negative and unknown states quick to set up.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [1:0] {
        POL_UNK = 2'd0,
        POL_POS = 2'd1,
        POL_NEG = 2'd2
    } pol_t;

    // Lower diode alone: current leaves the leg. Upper diode alone: current enters.
    function automatic pol_t pol_decode(input logic lo_cond, input logic hi_cond);
        if (lo_cond && !hi_cond) return POL_POS;
        if (hi_cond && !lo_cond) return POL_NEG;
        return POL_UNK;
    endfunction

    // Returns {upper, lower} wanted for a mode and command level.
    function automatic logic [1:0] gate_target(input pol_t m, input logic cmd);
        case (m)
            POL_POS: return {cmd, 1'b0};
            POL_NEG: return {1'b0, !cmd};
            default: return {cmd, !cmd};
        endcase
    endfunction

endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
        if (rst) stg_d = '0;
    end

    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/dtg_pol_filter.sv
module dtg_pol_filter
    import dtg_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lo_cond,
    input  logic hi_cond,
    output pol_t pol
);
    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        pol_t          cand;
        logic [CW-1:0] run;
        pol_t          pol;
    } filt_t;

    filt_t st_d, st_q;
    pol_t  raw;

    always_comb begin
        raw  = pol_decode(lo_cond, hi_cond);
        st_d = st_q;
        if (raw == st_q.cand) begin
            if (st_q.run != LAST) st_d.run = st_q.run + CW'(1);
        end else begin
            st_d.cand = raw;
            st_d.run  = '0;
        end
        if (st_q.run == LAST) st_d.pol = st_q.cand;
        if (rst) begin
            st_d.cand = POL_UNK;
            st_d.run  = '0;
            st_d.pol  = POL_UNK;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pol = st_q.pol;
endmodule

// File: rtl/dtg_gate_core.sv
module dtg_gate_core
    import dtg_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwm_cmd,
    input  pol_t            pol_in,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            gate_hi,
    output logic            gate_lo,
    output pol_t            mode
);
    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    typedef struct packed {
        pol_t            mode;
        logic            cmd;
        logic            blank;
        logic [DT_W-1:0] cnt;
        logic            hi;
        logic            lo;
    } core_t;

    core_t           st_d, st_q;
    logic            cmd_edge;
    logic            enter_comp;
    logic            clash;
    logic [1:0]      tgt;
    logic [DT_W-1:0] dead_load;

    always_comb begin
        st_d       = st_q;
        st_d.cmd   = pwm_cmd;
        cmd_edge   = (pwm_cmd != st_q.cmd);
        dead_load  = (dead_cnt == '0) ? ONE : dead_cnt;
        enter_comp = 1'b0;
        clash      = 1'b0;
        tgt        = gate_target(st_q.mode, pwm_cmd);

        if (cmd_edge) begin
            st_d.mode  = pol_in;
            tgt        = gate_target(pol_in, pwm_cmd);
            enter_comp = (pol_in == POL_UNK) && (st_q.mode != POL_UNK);
            clash      = (tgt[1] && st_q.lo) || (tgt[0] && st_q.hi);
            if (enter_comp || clash || st_q.blank) begin
                st_d.blank = 1'b1;
                st_d.cnt   = dead_load;
                st_d.hi    = 1'b0;
                st_d.lo    = 1'b0;
            end else begin
                st_d.hi    = tgt[1];
                st_d.lo    = tgt[0];
            end
        end else if (st_q.blank) begin
            if (st_q.cnt <= ONE) begin
                st_d.blank = 1'b0;
                st_d.cnt   = '0;
                st_d.hi    = tgt[1];
                st_d.lo    = tgt[0];
            end else begin
                st_d.cnt   = st_q.cnt - ONE;
            end
        end

        if (rst) begin
            st_d.mode  = POL_UNK;
            st_d.cmd   = 1'b0;
            st_d.blank = 1'b0;
            st_d.cnt   = '0;
            st_d.hi    = 1'b0;
            st_d.lo    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gate_hi = st_q.hi;
    assign gate_lo = st_q.lo;
    assign mode    = st_q.mode;
endmodule

// File: rtl/dtg_gate_ctrl.sv
module dtg_gate_ctrl
    import dtg_pkg::*;
#(
    parameter int DT_W     = 8,
    parameter int FILT_LEN = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwm_cmd,
    input  logic            dio_lo_cond,
    input  logic            dio_hi_cond,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            gate_hi,
    output logic            gate_lo
);
    logic [1:0] flags_s;
    pol_t       pol_q;
    pol_t       core_mode;

    dtg_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({dio_hi_cond, dio_lo_cond}),
        .dout (flags_s)
    );

    dtg_pol_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .lo_cond (flags_s[0]),
        .hi_cond (flags_s[1]),
        .pol     (pol_q)
    );

    dtg_gate_core #(.DT_W(DT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .pwm_cmd  (pwm_cmd),
        .pol_in   (pol_q),
        .dead_cnt (dead_cnt),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo),
        .mode     (core_mode)
    );
endmodule

// File: rtl/dtg_gate_checker.sv
module dtg_gate_checker
    import dtg_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic pwm_cmd,
    input logic gate_hi,
    input logic gate_lo,
    input pol_t mode
);
    // R1
    a_r1_no_overlap: assert property (@(posedge clk) !(gate_hi && gate_lo));

    // R2
    a_r2_reset_clears: assert property (@(posedge clk) rst |=> (!gate_hi && !gate_lo));

    // R5 / R10: a gate rises only after the other was low the cycle before
    a_r5_hi_after_lo_off: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> !$past(gate_lo));
    a_r5_lo_after_hi_off: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> !$past(gate_hi));

    // R6
    a_r6_pos_lower_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == POL_POS) |-> !gate_lo);

    // R7
    a_r7_neg_upper_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == POL_NEG) |-> !gate_hi);

    // R8
    a_r8_mode_edge_only: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && ($past(pwm_cmd) == $past(pwm_cmd, 2)))
        |-> $stable(mode));
endmodule

bind dtg_gate_ctrl dtg_gate_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .pwm_cmd (pwm_cmd),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .mode    (core_mode)
);

// File: tb/tb_dtg_gate_ctrl.sv
module tb_dtg_gate_ctrl;
    localparam int DT_W     = 5;
    localparam int FILT_LEN = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            pwm_cmd = 1'b0;
    logic            dio_lo_cond = 1'b0;
    logic            dio_hi_cond = 1'b0;
    logic [DT_W-1:0] dead_cnt = '0;
    logic            gate_hi, gate_lo;

    dtg_gate_ctrl #(.DT_W(DT_W), .FILT_LEN(FILT_LEN)) dut (
        .clk(clk), .rst(rst), .pwm_cmd(pwm_cmd),
        .dio_lo_cond(dio_lo_cond), .dio_hi_cond(dio_hi_cond),
        .dead_cnt(dead_cnt), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always #10 clk = ~clk; // 50 MHz

    typedef struct {
        int    cyc;
        bit    hi;
        bit    lo;
        string rq;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares the gates against queued expectations, away from the clock edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (e.cyc != cyc || gate_hi !== e.hi || gate_lo !== e.lo) begin
                n_fail++;
                $display("FAIL %s cycle %0d: hi=%b lo=%b expected hi=%b lo=%b",
                         e.rq, e.cyc, gate_hi, gate_lo, e.hi, e.lo);
            end
        end
    end

    task automatic push_exp(input int c, input bit hi, input bit lo, input string rq);
        exp_t e;
        e.cyc = c; e.hi = hi; e.lo = lo; e.rq = rq;
        sb.push_back(e);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive an edge; expect D cycles both off, then the target pair
    task automatic cmd_edge(input bit v, input bit th, input bit tl, input int d, input string rq);
        int c;
        @(negedge clk);
        pwm_cmd = v;
        c = cyc;
        for (int k = 1; k <= d; k++) push_exp(c + k, 1'b0, 1'b0, rq);
        push_exp(c + d + 1, th, tl, rq);
        settle(d + 3);
    endtask

    task automatic hold(input bit hi, input bit lo, input int n, input string rq);
        int c;
        @(negedge clk);
        c = cyc;
        for (int k = 1; k <= n; k++) push_exp(c + k, hi, lo, rq);
        settle(n + 1);
    endtask

    task automatic set_flags(input bit lo_f, input bit hi_f);
        @(negedge clk);
        dio_lo_cond = lo_f;
        dio_hi_cond = hi_f;
        settle(8);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        int c;
        // R2: reset holds both gates off even with the command high
        pwm_cmd = 1'b1;
        @(negedge clk);
        c = cyc;
        for (int k = 1; k <= 3; k++) push_exp(c + k, 1'b0, 1'b0, "R2");
        settle(4);
        pwm_cmd = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        hold(1'b0, 1'b0, 4, "R2");

        // R5 / R3: unknown (no flag), complementary with dead count 3
        dead_cnt = 5'd3;
        cmd_edge(1'b1, 1'b1, 1'b0, 0, "R5");
        cmd_edge(1'b0, 1'b0, 1'b1, 3, "R5");
        hold(1'b0, 1'b1, 3, "R5");
        cmd_edge(1'b1, 1'b1, 1'b0, 3, "R5");

        // R3: both flags set is still unknown; dead count 0 acts as 1
        set_flags(1'b1, 1'b1);
        dead_cnt = 5'd0;
        cmd_edge(1'b0, 1'b0, 1'b1, 1, "R3");
        cmd_edge(1'b1, 1'b1, 1'b0, 1, "R5");

        // R5: longest dead count
        dead_cnt = 5'd31;
        cmd_edge(1'b0, 1'b0, 1'b1, 31, "R5");
        cmd_edge(1'b1, 1'b1, 1'b0, 31, "R5");

        // R11: edge inside a dead interval restarts it
        dead_cnt = 5'd5;
        @(negedge clk);
        pwm_cmd = 1'b0;
        c = cyc;
        push_exp(c + 1, 1'b0, 1'b0, "R11");
        push_exp(c + 2, 1'b0, 1'b0, "R11");
        settle(1);
        cmd_edge(1'b1, 1'b1, 1'b0, 5, "R11");

        // R6: positive polarity (lower diode), upper only, no blanking
        set_flags(1'b1, 1'b0);
        hold(1'b1, 1'b0, 3, "R8");
        cmd_edge(1'b0, 1'b0, 1'b0, 0, "R6");
        cmd_edge(1'b1, 1'b1, 1'b0, 0, "R6");
        cmd_edge(1'b0, 1'b0, 1'b0, 0, "R6");
        hold(1'b0, 1'b0, 4, "R6");
        cmd_edge(1'b1, 1'b1, 1'b0, 0, "R6");

        // R4: two-cycle flag pulse toward negative is ignored
        @(negedge clk);
        dio_lo_cond = 1'b0; dio_hi_cond = 1'b1;
        settle(2);
        dio_lo_cond = 1'b1; dio_hi_cond = 1'b0;
        settle(8);
        cmd_edge(1'b0, 1'b0, 1'b0, 0, "R4");
        cmd_edge(1'b1, 1'b1, 1'b0, 0, "R4");

        // R8: polarity flips to negative between edges, gates unchanged
        set_flags(1'b0, 1'b1);
        hold(1'b1, 1'b0, 4, "R8");

        // R10: positive to negative with upper on inserts dead time
        cmd_edge(1'b0, 1'b0, 1'b1, 5, "R10");
        // R7: negative mode, lower follows inverted command
        cmd_edge(1'b1, 1'b0, 1'b0, 0, "R7");
        hold(1'b0, 1'b0, 4, "R7");
        cmd_edge(1'b0, 1'b0, 1'b1, 0, "R7");
        cmd_edge(1'b1, 1'b0, 1'b0, 0, "R7");

        // R9: entry into complementary blanks even with both gates off
        set_flags(1'b0, 1'b0);
        hold(1'b0, 1'b0, 3, "R8");
        cmd_edge(1'b0, 1'b0, 1'b1, 5, "R9");

        // R10: unknown to positive with lower on
        set_flags(1'b1, 1'b0);
        cmd_edge(1'b1, 1'b1, 1'b0, 5, "R10");

        settle(6);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", sb.size());
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end
endmodule